// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Decoder

This block is the host-facing control front end of a byte- or word-wide parallel flash device. It runs on a fast internal clock and watches the asynchronous bus pins: chip enable, output enable, write enable, a device reset pin, the address bus and the data bus. The data bus is presented as separate input, output and output-enable signals. From the synchronized control pins it decides, on every clock, whether the bus is in standby, a read, a write or an output-disabled state. During a read it drives the array's data onto the bus.

A write cycle can be framed by either write enable or chip enable. The block latches the address when the later of the two strobes falls, and the data when the earlier of the two rises. When the write completes it issues a single-clock command strobe with the latched address, the full latched data word, the low-byte command code and a two-bit sector code. The sector code places the address in the boot, parameter or main region of a bottom-boot or top-boot layout. A write with output enable low at any sampled point, or one cut by the device reset pin, is dropped without a strobe.

Top module: `pflash_bus_front`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `cmd_valid` and `bus_data_oe` are 0 and `cycle_kind` is 0.
- R2: `cycle_kind` follows the control pins two clocks after a change: 0 when the reset pin is low or chip enable is high, 2 when chip enable and write enable are both low, 1 when chip and output enable are low with write enable high, and 3 when chip enable is low with output and write enable high.
- R3: `bus_data_oe` is 1 and `bus_data_o` equals `array_rd_data` only when `cycle_kind` is 1. Otherwise `bus_data_oe` is 0 and `bus_data_o` is 0.
- R4: `cmd_addr` holds the address present when the later of chip enable and write enable went low. Address changes before that fall, or after it, have no effect.
- R5: `cmd_data` holds the data present when the earlier of the two strobes rose. The later rise captures nothing and issues no strobe.
- R6: Each accepted write gives exactly one `cmd_valid` pulse of one clock. It is seen on the third rising clock edge after the ending strobe rises.
- R7: A write during which output enable is sampled low gives no strobe and leaves `cmd_addr` and `cmd_data` unchanged. The next clean write is accepted.
- R8: While the device reset pin is low, the data bus is not driven and no strobe is issued. A write in progress when it falls is discarded, even if the strobes are still low when it rises.
- R9: `cmd_code` is bits 7:0 of the captured data. Bits above 7 never change it.
- R10: Bottom-boot layout (`TOP_BOOT`=0): with S = 2^(ADDR_W-5) and P = 2^(ADDR_W-6), addresses below S give sector code 3 (boot), [S, S+P) give 1, [S+P, S+2P) give 2, and the rest give 0 (main).
- R11: Top-boot layout (`TOP_BOOT`=1): the same regions are measured down from the highest address. The top S addresses give 3, the next P give 1, the next P give 2, and the rest give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset of the clock domain |
| bus_ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable pin, active low, asynchronous |
| bus_we_n | input | 1 | Write enable pin, active low, asynchronous |
| bus_rst_n | input | 1 | Device reset pin, active low, asynchronous |
| bus_addr | input | ADDR_W | Address bus |
| bus_data_i | input | DATA_W | Data bus as seen from the host |
| array_rd_data | input | DATA_W | Read data from the array at `bus_addr` |
| bus_data_o | output | DATA_W | Data driven toward the host |
| bus_data_oe | output | 1 | Data bus drive enable |
| cycle_kind | output | 2 | Current bus state code (see R2) |
| cmd_valid | output | 1 | One-clock strobe for an accepted write |
| cmd_addr | output | ADDR_W | Latched address of the last accepted write |
| cmd_data | output | DATA_W | Latched data of the last accepted write |
| cmd_code | output | 8 | Low byte of `cmd_data` |
| cmd_sector | output | 2 | Sector code of `cmd_addr` (see R10, R11) |

## Verification
All sixteen combinations of the reset pin, chip enable, output enable and write enable are swept with a different array word each time. This separates every bus state and shows that the drive enable tracks only the read state. Write cycles are driven in both framings, write-enable-framed and chip-enable-framed. The address changes before and after the later fall, and the data changes between the two rises, so a capture on the wrong edge returns a value the bench can tell apart. Aborted writes, with output enable low at the start, in the middle, or the reset pin pulsed, must leave the outputs still holding the last accepted values. An address sweep on both layouts at every parameter-sector boundary and its neighbour exercises each comparator edge of the sector map.

// File: rtl/pfb_pkg.sv
// Package: shared encodings for the parallel flash bus front end.
// Assumes: 2-bit codes are visible at the block's ports and must stay fixed.
package pfb_pkg;

    // Bus state as decoded from the synchronized control pins.
    typedef enum logic [1:0] {
        CYC_STANDBY = 2'd0,
        CYC_READ    = 2'd1,
        CYC_WRITE   = 2'd2,
        CYC_IDLE    = 2'd3
    } cyc_kind_e;

    // Region of the address space a command targets.
    typedef enum logic [1:0] {
        SEC_MAIN   = 2'd0,
        SEC_PARAM1 = 2'd1,
        SEC_PARAM2 = 2'd2,
        SEC_BOOT   = 2'd3
    } sector_e;

endpackage

// File: rtl/pfb_sync.sv
// Module: multi-bit chain of flip-flops that brings asynchronous pins into
// the clk domain.
// Assumes: each bit is independent (no multi-bit coherence is needed) and
// STAGES is at least 2.
module pfb_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the pin values through the chain; reset loads the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pfb_read_ctrl.sv
// Module: decodes the synchronized control levels into a bus state and
// drives array data toward the host only while a read is in progress.
// Assumes: inputs are already synchronized; outputs are combinational.
module pfb_read_ctrl
    import pfb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              dev_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] rd_data,
    output cyc_kind_e         kind,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe
);

    // Priority decode: reset pin and chip enable first, then write, then read.
    always_comb begin
        if (!dev_ok || ce_n) begin
            kind = CYC_STANDBY;
        end else if (!we_n) begin
            kind = CYC_WRITE;
        end else if (!oe_n) begin
            kind = CYC_READ;
        end else begin
            kind = CYC_IDLE;
        end
    end

    // Drive the bus only for reads; park the data lines at zero otherwise.
    always_comb begin
        data_oe = (kind == CYC_READ);
        data_o  = data_oe ? rd_data : '0;
    end

endmodule

// File: rtl/pfb_write_capture.sv
// Module: frames write cycles from the synchronized strobes, latches the
// address at the later falling strobe and the data at the earlier rising
// strobe, and publishes an accepted command with a one-clock pulse.
// Assumes: the host holds address and data stable for at least SYNC+1 clocks
// around the framing edges; a write requires OE high for its whole length.
module pfb_write_capture #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    logic              strobe_low;
    logic              strobe_q;
    logic              open_q;
    logic              oe_clean_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              begin_w;
    logic              end_w;

    // Both strobes low means a write is being framed.
    assign strobe_low = !ce_n && !we_n;
    assign begin_w    = strobe_low && !strobe_q;
    assign end_w      = !strobe_low && strobe_q;

    // Track the framing strobe so its edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_low;
        end
    end

    // Open/close a write, watch OE across it, and hold the pending address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q      <= 1'b0;
            oe_clean_q  <= 1'b0;
            pend_addr_q <= '0;
        end else if (!dev_ok) begin
            open_q      <= 1'b0;
            oe_clean_q  <= 1'b0;
        end else if (begin_w) begin
            open_q      <= 1'b1;
            oe_clean_q  <= oe_n;
            pend_addr_q <= addr;
        end else if (end_w) begin
            open_q      <= 1'b0;
        end else if (open_q && !oe_n) begin
            oe_clean_q  <= 1'b0;
        end
    end

    // Publish an accepted write: latch data and address, pulse for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (dev_ok && end_w && open_q && oe_clean_q && oe_n) begin
                cmd_valid <= 1'b1;
                cmd_addr  <= pend_addr_q;
                cmd_data  <= data;
            end
        end
    end

endmodule

// File: rtl/pfb_sector_map.sv
// Module: classifies an address into boot, parameter or main sector for a
// bottom-boot or top-boot layout chosen by TOP_BOOT.
// Assumes: boot region is 1/32 of the space and each parameter sector 1/64;
// the top layout is the bitwise mirror of the bottom one.
module pfb_sector_map
    import pfb_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output sector_e           sector
);

    localparam int unsigned     BOOT_SPAN  = 2 ** (ADDR_W - 5);
    localparam int unsigned     PARAM_SPAN = 2 ** (ADDR_W - 6);
    localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(BOOT_SPAN);
    localparam logic [ADDR_W-1:0] LIM_P1   = ADDR_W'(BOOT_SPAN + PARAM_SPAN);
    localparam logic [ADDR_W-1:0] LIM_P2   = ADDR_W'(BOOT_SPAN + 2 * PARAM_SPAN);

    logic [ADDR_W-1:0] rel;

    // Fold the top layout onto the bottom one by inverting the address.
    generate
        if (TOP_BOOT) begin : g_top
            assign rel = ~addr;
        end else begin : g_bottom
            assign rel = addr;
        end
    endgenerate

    // Single comparator chain measured from the boot end of the space.
    always_comb begin
        if (rel < LIM_BOOT) begin
            sector = SEC_BOOT;
        end else if (rel < LIM_P1) begin
            sector = SEC_PARAM1;
        end else if (rel < LIM_P2) begin
            sector = SEC_PARAM2;
        end else begin
            sector = SEC_MAIN;
        end
    end

endmodule

// File: rtl/pflash_bus_front.sv
// Module: top of the parallel flash bus front end. Synchronizes the control
// pins, decodes bus state, drives read data, captures write commands and
// tags them with their sector.
// Assumes: DATA_W is 8 or more; address/data meet the hold noted in
// pfb_write_capture; the array supplies array_rd_data for bus_addr.
module pflash_bus_front
    import pfb_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter bit TOP_BOOT    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [DATA_W-1:0] array_rd_data,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    output logic [1:0]        cycle_kind,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [7:0]        cmd_code,
    output logic [1:0]        cmd_sector
);

    localparam int CTRL_W = 4;
    localparam int CODE_W = 8;

    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_sync;
    logic              dev_ok;
    logic              s_ce_n;
    logic              s_oe_n;
    logic              s_we_n;
    cyc_kind_e         kind_w;
    sector_e           sector_w;

    // Bundle the asynchronous pins; reset pin syncs in as asserted.
    assign ctrl_raw = {bus_rst_n, bus_ce_n, bus_oe_n, bus_we_n};

    pfb_sync #(
        .W       (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctrl_raw),
        .q     (ctrl_sync)
    );

    assign {dev_ok, s_ce_n, s_oe_n, s_we_n} = ctrl_sync;

    pfb_read_ctrl #(
        .DATA_W (DATA_W)
    ) u_read (
        .dev_ok  (dev_ok),
        .ce_n    (s_ce_n),
        .oe_n    (s_oe_n),
        .we_n    (s_we_n),
        .rd_data (array_rd_data),
        .kind    (kind_w),
        .data_o  (bus_data_o),
        .data_oe (bus_data_oe)
    );

    pfb_write_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_write (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_ok    (dev_ok),
        .ce_n      (s_ce_n),
        .oe_n      (s_oe_n),
        .we_n      (s_we_n),
        .addr      (bus_addr),
        .data      (bus_data_i),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    pfb_sector_map #(
        .ADDR_W   (ADDR_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_sector (
        .addr   (cmd_addr),
        .sector (sector_w)
    );

    // Present the decoded codes and the command byte at the ports.
    assign cycle_kind = kind_w;
    assign cmd_sector = sector_w;
    assign cmd_code   = cmd_data[CODE_W-1:0];

endmodule

// File: rtl/pflash_bus_front_chk.sv
// Module: protocol checker for pflash_bus_front, attached by bind.
// Assumes: sees the synchronized reset-pin and OE levels inside the top.
module pflash_bus_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dev_ok,
    input logic       s_oe_n,
    input logic       data_oe,
    input logic       cmd_valid,
    input logic [1:0] cyc_kind
);

    // R1: reset clears the strobe and the bus drive.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !data_oe));

    // R3: the bus is driven only in the read state.
    assert_drive_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (cyc_kind == 2'd1));

    // R6: the command strobe lasts a single clock.
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7: an accepted write saw OE high on its closing sample.
    assert_oe_high_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(s_oe_n));

    // R8: device reset blocks the strobe on the next clock and the drive now.
    assert_devreset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ok |=> !cmd_valid);

    assert_devreset_nodrive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ok |-> !data_oe);

endmodule

bind pflash_bus_front pflash_bus_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_ok    (dev_ok),
    .s_oe_n    (s_oe_n),
    .data_oe   (bus_data_oe),
    .cmd_valid (cmd_valid),
    .cyc_kind  (cycle_kind)
);

// File: tb/pflash_bus_front_tb.sv
// Bench: word-wide configuration, bottom-boot (u_dut) and top-boot
// (u_dut_top) instances on a shared bus; expected values from arithmetic.
module pflash_bus_front_tb;

    localparam int AW = 18;
    localparam int DW = 16;
    localparam int BOOT = 2 ** (AW - 5);
    localparam int PAR  = 2 ** (AW - 6);
    localparam int FULL = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dev_rst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0, rd = '0;

    logic [DW-1:0] dout, dout_t, cdata, cdata_t;
    logic          doe, doe_t, cv, cv_t;
    logic [1:0]    kind, kind_t, csec, csec_t;
    logic [AW-1:0] caddr, caddr_t;
    logic [7:0]    ccode, ccode_t;

    int n_checks = 0;
    int n_fail   = 0;
    int got_cnt, got_idx;
    logic [AW-1:0] got_addr;
    logic [DW-1:0] got_data;
    logic [7:0]    got_code;
    logic [1:0]    got_sec, got_sec_t;

    always #10 clk = ~clk;

    pflash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .TOP_BOOT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n),
        .bus_we_n(we_n), .bus_rst_n(dev_rst_n), .bus_addr(addr),
        .bus_data_i(din), .array_rd_data(rd), .bus_data_o(dout),
        .bus_data_oe(doe), .cycle_kind(kind), .cmd_valid(cv),
        .cmd_addr(caddr), .cmd_data(cdata), .cmd_code(ccode),
        .cmd_sector(csec));

    pflash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .TOP_BOOT(1'b1)) u_dut_top (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n),
        .bus_we_n(we_n), .bus_rst_n(dev_rst_n), .bus_addr(addr),
        .bus_data_i(din), .array_rd_data(rd), .bus_data_o(dout_t),
        .bus_data_oe(doe_t), .cycle_kind(kind_t), .cmd_valid(cv_t),
        .cmd_addr(caddr_t), .cmd_data(cdata_t), .cmd_code(ccode_t),
        .cmd_sector(csec_t));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sample n falling edges and record any command strobe seen.
    task automatic watch(input int n);
        got_cnt = 0;
        got_idx = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (cv) begin
                got_cnt++;
                got_idx   = i;
                got_addr  = caddr;
                got_data  = cdata;
                got_code  = ccode;
                got_sec   = csec;
                got_sec_t = csec_t;
            end
        end
    endtask

    // Plain WE-framed write.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
        tick(2);
        we_n = 1'b0;
        tick(4);
        we_n = 1'b1;
        watch(8);
        ce_n = 1'b1;
        tick(3);
    endtask

    function automatic logic [1:0] exp_kind(input logic r, input logic c,
                                            input logic o, input logic w);
        if (!r || c)  return 2'd0;
        else if (!w)  return 2'd2;
        else if (!o)  return 2'd1;
        else          return 2'd3;
    endfunction

    function automatic logic [1:0] exp_sec_bottom(input int a);
        if (a < BOOT)                return 2'd3;
        else if (a < BOOT + PAR)     return 2'd1;
        else if (a < BOOT + 2 * PAR) return 2'd2;
        else                         return 2'd0;
    endfunction

    function automatic logic [1:0] exp_sec_top(input int a);
        if (a >= FULL - BOOT)                return 2'd3;
        else if (a >= FULL - BOOT - PAR)     return 2'd1;
        else if (a >= FULL - BOOT - 2 * PAR) return 2'd2;
        else                                 return 2'd0;
    endfunction

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0x1 expected=0x0");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] last_addr;
        logic [DW-1:0] last_data;

        // R1: reset state
        tick(3);
        chk("R1 cmd_valid in reset", 32'(cv), 32'd0);
        chk("R1 data_oe in reset", 32'(doe), 32'd0);
        chk("R1 kind in reset", 32'(kind), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_valid after reset", 32'(cv), 32'd0);
        chk("R1 data_oe after reset", 32'(doe), 32'd0);
        tick(3);
        chk("R1 kind idle pins", 32'(kind), 32'd0);

        // R2 / R3: every control-pin combination
        for (int v = 0; v < 16; v++) begin
            logic [3:0] p;
            logic [1:0] ek;
            p = 4'(v);
            {dev_rst_n, ce_n, oe_n, we_n} = p;
            rd = DW'(v * 16'h1111) ^ 16'hA5A5;
            tick(3);
            ek = exp_kind(p[3], p[2], p[1], p[0]);
            chk("R2 kind sweep", 32'(kind), 32'(ek));
            chk("R2 kind sweep top", 32'(kind_t), 32'(ek));
            chk("R3 drive enable", 32'(doe), 32'(ek == 2'd1));
            chk("R3 drive data", 32'(dout), (ek == 2'd1) ? 32'(rd) : 32'd0);
        end
        {dev_rst_n, ce_n, oe_n, we_n} = 4'b1111;
        tick(6);

        // R4: WE falls later, address moved before and after that fall
        addr = 18'h01234; din = 16'h0042; ce_n = 1'b0;
        tick(4);
        addr = 18'h2ABCD; we_n = 1'b0;
        tick(4);
        addr = 18'h3FFFF;
        tick(3);
        we_n = 1'b1;
        watch(8);
        chk("R6 one strobe", 32'(got_cnt), 32'd1);
        chk("R6 strobe cycle", 32'(got_idx), 32'd3);
        chk("R4 later fall WE", 32'(got_addr), 32'h2ABCD);
        ce_n = 1'b1;
        tick(3);

        // R4: CE falls later, CE also rises first
        addr = 18'h00111; din = 16'h0077; we_n = 1'b0;
        tick(4);
        addr = 18'h15555; ce_n = 1'b0;
        tick(4);
        addr = 18'h00222;
        tick(3);
        ce_n = 1'b1;
        watch(8);
        chk("R6 one strobe CE framed", 32'(got_cnt), 32'd1);
        chk("R4 later fall CE", 32'(got_addr), 32'h15555);
        we_n = 1'b1;
        tick(3);

        // R5: WE rises first, data changed before CE rises
        addr = 18'h00333; din = 16'h1357; ce_n = 1'b0; we_n = 1'b0;
        tick(5);
        we_n = 1'b1;
        watch(8);
        chk("R5 first rise WE count", 32'(got_cnt), 32'd1);
        chk("R5 first rise WE data", 32'(got_data), 32'h1357);
        din = 16'h9BDF; ce_n = 1'b1;
        watch(8);
        chk("R5 later rise no strobe", 32'(got_cnt), 32'd0);
        chk("R5 data kept", 32'(cdata), 32'h1357);

        // R5: CE rises first
        addr = 18'h00444; din = 16'h2468; ce_n = 1'b0; we_n = 1'b0;
        tick(5);
        ce_n = 1'b1;
        watch(8);
        chk("R5 first rise CE data", 32'(got_data), 32'h2468);
        din = 16'hACE0; we_n = 1'b1;
        watch(8);
        chk("R5 later rise WE no strobe", 32'(got_cnt), 32'd0);
        chk("R5 data kept CE", 32'(cdata), 32'h2468);
        last_addr = 18'h00444;
        last_data = 16'h2468;

        // R7: OE dips low mid-write
        addr = 18'h11111; din = 16'h5555; ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        oe_n = 1'b0;
        tick(3);
        oe_n = 1'b1;
        tick(3);
        we_n = 1'b1;
        watch(8);
        chk("R7 OE dip no strobe", 32'(got_cnt), 32'd0);
        chk("R7 OE dip addr kept", 32'(caddr), 32'(last_addr));
        chk("R7 OE dip data kept", 32'(cdata), 32'(last_data));
        ce_n = 1'b1;
        tick(3);

        // R7: OE low at the start of the write
        oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        oe_n = 1'b1;
        tick(4);
        we_n = 1'b1;
        watch(8);
        chk("R7 OE low at start no strobe", 32'(got_cnt), 32'd0);
        ce_n = 1'b1;
        tick(3);

        // R7: a clean write afterwards is accepted
        wr(18'h22222, 16'h6666);
        chk("R7 recovery strobe", 32'(got_cnt), 32'd1);
        chk("R7 recovery addr", 32'(got_addr), 32'h22222);
        last_addr = 18'h22222;
        last_data = 16'h6666;

        // R8: device reset cuts a write in progress
        addr = 18'h33333; din = 16'h7777; ce_n = 1'b0; we_n = 1'b0;
        tick(4);
        dev_rst_n = 1'b0;
        tick(4);
        chk("R8 no drive in reset", 32'(doe), 32'd0);
        chk("R8 standby in reset", 32'(kind), 32'd0);
        dev_rst_n = 1'b1;
        tick(4);
        we_n = 1'b1;
        watch(8);
        chk("R8 partial write dropped", 32'(got_cnt), 32'd0);
        chk("R8 addr kept", 32'(caddr), 32'(last_addr));
        chk("R8 data kept", 32'(cdata), 32'(last_data));
        ce_n = 1'b1;
        tick(3);

        // R8: read attempt while the reset pin is low, then released
        rd = 16'hBEEF; dev_rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        tick(3);
        chk("R8 read blocked", 32'(doe), 32'd0);
        chk("R8 read data parked", 32'(dout), 32'd0);
        dev_rst_n = 1'b1;
        tick(3);
        chk("R3 read after release", 32'(doe), 32'd1);
        chk("R3 read data", 32'(dout), 32'hBEEF);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(3);

        // R9: high byte does not reach the command code
        wr(18'h00055, 16'hAB5C);
        chk("R9 code low byte", 32'(got_code), 32'h5C);
        chk("R9 full data", 32'(got_data), 32'hAB5C);
        wr(18'h00055, 16'h545C);
        chk("R9 code unchanged by high byte", 32'(got_code), 32'h5C);

        // R10 / R11: sector sweep at every 4K-word boundary and its neighbour
        for (int k = 0; k < FULL / PAR; k++) begin
            for (int e = 0; e < 2; e++) begin
                int a;
                a = k * PAR + e * (PAR - 1);
                wr(AW'(a), DW'(a));
                chk("R6 sweep strobe", 32'(got_cnt), 32'd1);
                chk("R10 bottom sector", 32'(got_sec), 32'(exp_sec_bottom(a)));
                chk("R11 top sector", 32'(got_sec_t), 32'(exp_sec_top(a)));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule